// File: doc/BRIEF.md
# Configuration Register I2C Target

This block is an I2C target that gives a host byte-wide access to five configuration and status registers of a display-path switch controller. Two bits of its 7-bit bus address come from strap pins. The rest of the chip uses the register contents through parallel outputs.

A write transaction loads an index pointer from its first data byte. Every later data byte is stored at the pointer, and the pointer then advances by one. A read transaction returns bytes starting at the current pointer, which advances after each byte. Repeating a START after an index-only write therefore reads from a chosen index.

SCL and SDA are resynchronised into the system clock. The block only pulls SDA low, and it changes its drive only while SCL is low.

Top module: `cfg_i2c_target`

## Requirements
- R1: The target acknowledges only the address byte {1,0,1,1,A2,A1,1,RW}, where A2 is `addr_strap_i[1]`, A1 is `addr_strap_i[0]` and RW=1 means read. For any other address it leaves SDA released (NACK) and ignores the bus until the next START.
- R2: In a write, the first data byte sets the index. Each following byte is written at the index, and the index then increments. The target ACKs every data byte by pulling SDA low during the ninth clock.
- R3: In a read, the target sends bytes MSB first, starting at the current index, and the index increments after each byte. It keeps sending while the master ACKs, and it releases the bus after a master NACK.
- R4: While reset is asserted and after it, `sel_ctrl_o` (index 0x00), `eq_ctrl_o` (index 0x01), `tx_ctrl_o` (index 0x02) and `hp_ctrl_o` (index 0x04 bits [7:4]) are all zero. Each output shows the stored bits of its register.
- R5: Index 0x03 always reads 0x51, and writes to it have no effect on any output.
- R6: At index 0x04, bits [7:4] are read/write. Bits [3:1] read back the live inputs `hpd_i[2]`, `hpd_i[1]` and `hpd_i[0]`, and bit 0 reads 0.
- R7: Bit 0 of index 0x00 and bit 0 of index 0x02 ignore writes and read as 0. All eight bits of index 0x01 are writable.
- R8: A write to an index above 0x04 is ACKed but changes nothing. A read from such an index returns 0x00.
- R9: A START in the middle of a byte abandons the transfer and restarts address reception. After a STOP the target returns to idle with SDA released.
- R10: SDA is only ever driven low. A new low drive begins only while SCL is low, and it is held steady for as long as SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line, asynchronous |
| sda_i | input | 1 | I2C data line as seen on the bus, asynchronous |
| addr_strap_i | input | 2 | Strap bits: [1] is A2, [0] is A1 |
| hpd_i | input | 3 | Live hot-plug levels of ports 3..1 ([2] is port 3) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| sel_ctrl_o | output | 8 | Register 0x00: standby, manual port, priority code, input type |
| eq_ctrl_o | output | 8 | Register 0x01: equalisation code and hot-plug timer settings |
| tx_ctrl_o | output | 8 | Register 0x02: output mode, pre-emphasis, swing, slew |
| hp_ctrl_o | output | 4 | Register 0x04 bits [7:4]: hot-plug inversion, DDC mode, blanking disable, t2 select |

## Verification
A bit counter or sequencer state that goes wrong shows at the ports within one byte time. The ninth-clock ACK then lands on the wrong SCL pulse, or a read byte returns shifted bits. A pointer that goes wrong stays hidden until the next data byte, which then either writes the wrong parallel output or reads back a value the model does not expect. The bench compares the parallel outputs against its model on every clock of idle bus time, and it compares each ACK bit and each read byte as it is clocked out.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_RNEXT
    } i2c_state_e;

    localparam int          BYTE_W    = 8;
    localparam logic [7:0]  ID_VALUE  = 8'h51;
    localparam logic [3:0]  ADDR_HIGH = 4'b1011;
    localparam int          RW_SLOTS  = 4;

    typedef struct packed {
        i2c_state_e         st;
        logic [2:0]         bits;
        logic [BYTE_W-1:0]  sh;
        logic [BYTE_W-1:0]  ptr;
        logic               idx_pend;
        logic               oe;
    } seq_t;

endpackage

// File: rtl/cfg_i2c_line_sync.sv
module cfg_i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int PIPE_W = STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] scl;
        logic [PIPE_W-1:0] sda;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d.scl = {pipe_q.scl[PIPE_W-2:0], scl_i};
        pipe_d.sda = {pipe_q.sda[PIPE_W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    logic scl_p, sda_p;
    assign scl_s     = pipe_q.scl[STAGES-1];
    assign sda_s     = pipe_q.sda[STAGES-1];
    assign scl_p     = pipe_q.scl[STAGES];
    assign sda_p     = pipe_q.sda[STAGES];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/cfg_i2c_regbank.sv
module cfg_i2c_regbank
    import cfg_i2c_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [2:0]        hpd_live,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] slot_o [RW_SLOTS]
);
    localparam logic [BYTE_W-1:0] WMASK [RW_SLOTS] = '{8'hFE, 8'hFF, 8'hFE, 8'hF0};
    localparam int                ID_IDX           = 3;
    localparam int                HP_IDX           = 4;

    logic [BYTE_W-1:0]   slot_d [RW_SLOTS];
    logic [BYTE_W-1:0]   slot_q [RW_SLOTS];
    logic [RW_SLOTS-1:0] hit;

    for (genvar s = 0; s < RW_SLOTS; s++) begin : g_slot
        localparam int SLOT_IDX = (s == RW_SLOTS - 1) ? HP_IDX : s;
        assign hit[s]    = wr_en && (wr_idx == SLOT_IDX[IDX_W-1:0]);
        assign slot_o[s] = slot_q[s];
    end

    always_comb begin
        for (int s = 0; s < RW_SLOTS; s++) begin
            slot_d[s] = hit[s] ? (wr_data & WMASK[s]) : slot_q[s];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < RW_SLOTS; s++) slot_q[s] <= '0;
        end else begin
            for (int s = 0; s < RW_SLOTS; s++) slot_q[s] <= slot_d[s];
        end
    end

    always_comb begin
        if (rd_idx < IDX_W'(ID_IDX))       rd_data = slot_q[rd_idx[1:0]];
        else if (rd_idx == IDX_W'(ID_IDX)) rd_data = ID_VALUE;
        else if (rd_idx == IDX_W'(HP_IDX)) rd_data = {slot_q[RW_SLOTS-1][7:4], hpd_live, 1'b0};
        else                               rd_data = '0;
    end
endmodule

// File: rtl/cfg_i2c_sequencer.sv
module cfg_i2c_sequencer
    import cfg_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [6:0]        dev_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] ptr,
    output logic              sda_oe
);
    seq_t q, d;
    logic [BYTE_W-1:0] sh_in;

    assign sh_in   = {q.sh[BYTE_W-2:0], sda_s};
    assign wr_idx  = q.ptr;
    assign wr_data = sh_in;
    assign ptr     = q.ptr;
    assign sda_oe  = q.oe;

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (start_det) begin
            d.st   = ST_ADDR;
            d.bits = '0;
            d.oe   = 1'b0;
        end else if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: if (scl_rise) begin
                    d.sh   = sh_in;
                    d.bits = q.bits + 3'd1;
                    if (q.bits == 3'd7) begin
                        if (sh_in[7:1] == dev_addr) begin
                            d.st       = ST_AACK;
                            d.idx_pend = ~sh_in[0];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK: if (scl_fall) begin
                    if (!q.oe) begin
                        d.oe = 1'b1;
                    end else if (q.sh[0]) begin
                        d.st   = ST_RDATA;
                        d.sh   = rd_data;
                        d.oe   = ~rd_data[7];
                        d.bits = '0;
                    end else begin
                        d.st   = ST_WDATA;
                        d.oe   = 1'b0;
                        d.bits = '0;
                    end
                end
                ST_WDATA: if (scl_rise) begin
                    d.sh   = sh_in;
                    d.bits = q.bits + 3'd1;
                    if (q.bits == 3'd7) begin
                        d.st = ST_WACK;
                        if (q.idx_pend) begin
                            d.ptr      = sh_in;
                            d.idx_pend = 1'b0;
                        end else begin
                            wr_en = 1'b1;
                            d.ptr = q.ptr + 8'd1;
                        end
                    end
                end
                ST_WACK: if (scl_fall) begin
                    if (!q.oe) begin
                        d.oe = 1'b1;
                    end else begin
                        d.oe   = 1'b0;
                        d.st   = ST_WDATA;
                        d.bits = '0;
                    end
                end
                ST_RDATA: if (scl_fall) begin
                    if (q.bits == 3'd7) begin
                        d.oe  = 1'b0;
                        d.st  = ST_RACK;
                        d.ptr = q.ptr + 8'd1;
                    end else begin
                        d.sh   = {q.sh[BYTE_W-2:0], 1'b0};
                        d.oe   = ~q.sh[6];
                        d.bits = q.bits + 3'd1;
                    end
                end
                ST_RACK: if (scl_rise) begin
                    d.st = sda_s ? ST_IDLE : ST_RNEXT;
                end
                ST_RNEXT: if (scl_fall) begin
                    d.st   = ST_RDATA;
                    d.sh   = rd_data;
                    d.oe   = ~rd_data[7];
                    d.bits = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, bits: '0, sh: '0, ptr: '0, idx_pend: 1'b0, oe: 1'b0};
        else        q <= d;
    end
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
    import cfg_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] addr_strap_i,
    input  logic [2:0] hpd_i,
    output logic       sda_oe_o,
    output logic [7:0] sel_ctrl_o,
    output logic [7:0] eq_ctrl_o,
    output logic [7:0] tx_ctrl_o,
    output logic [3:0] hp_ctrl_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en;
    logic [BYTE_W-1:0] wr_idx, wr_data, ptr, rd_data;
    logic [BYTE_W-1:0] slot [RW_SLOTS];
    logic [6:0] dev_addr;

    assign dev_addr = {ADDR_HIGH, addr_strap_i[1], addr_strap_i[0], 1'b1};

    cfg_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cfg_i2c_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .dev_addr(dev_addr), .rd_data(rd_data), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .ptr(ptr), .sda_oe(sda_oe_o)
    );

    cfg_i2c_regbank #(.IDX_W(BYTE_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(ptr), .hpd_live(hpd_i),
        .rd_data(rd_data), .slot_o(slot)
    );

    assign sel_ctrl_o = slot[0];
    assign eq_ctrl_o  = slot[1];
    assign tx_ctrl_o  = slot[2];
    assign hp_ctrl_o  = slot[3][7:4];
endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       stop_det,
    input logic       sda_oe,
    input logic [7:0] sel,
    input logic [7:0] eq,
    input logic [7:0] tx,
    input logic [3:0] hp
);
    assert_drive_starts_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s));

    assert_drive_held_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_s) && scl_s && $past(sda_oe)) |-> sda_oe);

    assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    assert_write_on_scl_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sel) || !$stable(eq) || !$stable(tx) || !$stable(hp)) |-> $past(scl_s));

    assert_reset_clears_R4: assert property (@(posedge clk)
        !rst_n |=> (sel == 8'h00 && eq == 8'h00 && tx == 8'h00 && hp == 4'h0));
endmodule

bind cfg_i2c_target cfg_i2c_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
    .sda_oe(sda_oe_o), .sel(sel_ctrl_o), .eq(eq_ctrl_o), .tx(tx_ctrl_o), .hp(hp_ctrl_o)
);

// File: tb/sim_cfg_i2c_target.sv
module sim_cfg_i2c_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int WDOG       = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic [2:0] hpd = 3'b000;
    logic sda_oe;
    logic [7:0] sel, eq, tx;
    logic [3:0] hp;
    wire  sda_bus = sda_m & ~sda_oe;

    int vectors = 0, fails = 0, cyc = 0;
    bit quiet = 1'b0, done = 1'b0;
    logic [7:0] m_reg [0:4];
    int m_ptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_i2c_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_strap_i(strap), .hpd_i(hpd), .sda_oe_o(sda_oe),
        .sel_ctrl_o(sel), .eq_ctrl_o(eq), .tx_ctrl_o(tx), .hp_ctrl_o(hp)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input int idx);
        if (idx < 3)       return m_reg[idx];
        else if (idx == 3) return 8'h51;
        else if (idx == 4) return {m_reg[4][7:4], hpd, 1'b0};
        else               return 8'h00;
    endfunction

    function automatic void m_write(input int idx, input logic [7:0] v);
        case (idx)
            0: m_reg[0] = v & 8'hFE;
            1: m_reg[1] = v;
            2: m_reg[2] = v & 8'hFE;
            4: m_reg[4] = v & 8'hF0;
            default: ;
        endcase
    endfunction

    // Per-clock comparison of parallel outputs while the bus is quiet (R4..R8)
    always @(negedge clk) begin
        if (rst_n && quiet && !done) begin
            check(sel == m_reg[0], "R4 sel_ctrl", sel, m_reg[0]);
            check(eq  == m_reg[1], "R7 eq_ctrl", eq, m_reg[1]);
            check(tx  == m_reg[2], "R7 tx_ctrl", tx, m_reg[2]);
            check(hp  == m_reg[4][7:4], "R6 hp_ctrl", hp, m_reg[4][7:4]);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        acked = (sda_bus == 1'b0);
        wq(Q); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
            b[i] = sda_bus;
            wq(Q); scl_m = 1'b0;
        end
        send_bit(!ack);
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] s, input bit rd);
        return {4'b1011, s, 1'b1, rd};
    endfunction

    // Write: index byte then n data bytes; model follows R2/R5/R7/R8
    task automatic write_regs(input logic [7:0] idx, input logic [7:0] data [4], input int n, input string req);
        bit a;
        quiet = 1'b0;
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        check(a, {"R1 addr ack ", req}, a, 1);
        send_byte(idx, a);
        check(a, {"R2 index ack ", req}, a, 1);
        m_ptr = idx;
        for (int k = 0; k < n; k++) begin
            send_byte(data[k], a);
            check(a, {"R2 data ack ", req}, a, 1);
            m_write(m_ptr, data[k]);
            m_ptr = (m_ptr + 1) % 256;
        end
        bus_stop();
        wq(Q);
        quiet = 1'b1;
    endtask

    // Set index, repeated START, read n bytes (R3)
    task automatic read_regs(input logic [7:0] idx, input int n, input string req);
        bit a;
        logic [7:0] b;
        quiet = 1'b0;
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        check(a, {"R1 addr ack ", req}, a, 1);
        send_byte(idx, a);
        check(a, {"R2 index ack ", req}, a, 1);
        m_ptr = idx;
        bus_start();
        send_byte(addr_byte(strap, 1'b1), a);
        check(a, {"R1 read addr ack ", req}, a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            check(b == m_read(m_ptr), {"R3 read data ", req}, b, m_read(m_ptr));
            m_ptr = (m_ptr + 1) % 256;
        end
        bus_stop();
        wq(Q);
        quiet = 1'b1;
    endtask

    initial begin
        bit a;
        for (int i = 0; i < 5; i++) m_reg[i] = 8'h00;
        m_reg[3] = 8'h51;
        wq(4);
        check(sel == 0 && eq == 0 && tx == 0 && hp == 0 && sda_oe == 0, "R4 reset state",
              {sel, eq, tx, hp, 3'b0, sda_oe}, 0);
        rst_n = 1'b1;
        quiet = 1'b1;
        wq(10);

        // R2, R7: burst across 0x00..0x02, reserved bits drop
        write_regs(8'h00, '{8'hFF, 8'hA5, 8'hC3, 8'h00}, 3, "burst 0-2");
        // R5, R6: write across ID register into 0x04
        write_regs(8'h03, '{8'h00, 8'hF5, 8'h00, 8'h00}, 2, "id and hp");
        check(hp == 4'hF, "R6 hp upper written", hp, 4'hF);
        hpd = 3'b101;
        // R3, R5, R6, R8: read 0x00..0x05 in one burst
        read_regs(8'h00, 6, "full burst");
        // R8: out-of-range write ACKed and discarded
        write_regs(8'h07, '{8'hAA, 8'h55, 8'h00, 8'h00}, 2, "out of range");
        read_regs(8'h06, 2, "out of range read");

        // R1: wrong strap address gets NACK and data is ignored
        quiet = 1'b0;
        bus_start();
        send_byte(addr_byte(strap ^ 2'b01, 1'b0), a);
        check(!a, "R1 wrong address nack", a, 0);
        send_byte(8'h01, a);
        check(!a, "R1 ignored after nack", a, 0);
        send_byte(8'h00, a);
        check(!a, "R1 ignored after nack", a, 0);
        bus_stop();
        wq(Q);
        quiet = 1'b1;
        wq(4);

        // R9: START in the middle of the address byte restarts reception
        quiet = 1'b0;
        bus_start();
        for (int i = 7; i >= 4; i--) send_bit(addr_byte(strap, 1'b0)[i]);
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        check(a, "R9 restart addr ack", a, 1);
        send_byte(8'h01, a);
        send_byte(8'h3C, a);
        check(a, "R9 data ack after restart", a, 1);
        m_write(1, 8'h3C);
        bus_stop();
        wq(Q);
        check(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
        quiet = 1'b1;
        check(eq == 8'h3C, "R9 write after restart", eq, 8'h3C);

        // R1: different strap setting, R6 live status changes
        strap = 2'b01;
        hpd = 3'b010;
        read_regs(8'h04, 1, "new strap");
        write_regs(8'h04, '{8'h0F, 8'h00, 8'h00, 8'h00}, 1, "hp clear");
        check(hp == 4'h0, "R6 hp cleared", hp, 4'h0);
        read_regs(8'h02, 3, "tail burst");
        check(sda_oe == 1'b0, "R10 released at idle", sda_oe, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule